// File: doc/BRIEF.md
# Synchronous Serial Byte Port

A full-duplex clocked serial unit that shifts one 8-bit byte out on `sdo` while it shifts one byte in from `sdi`, most-significant bit first. As a master it makes its own shift clock from the system clock. A prescaler divides the system clock by 1, 2, 8 or 32, and an 8-bit divider sets the half period from there. As a slave it follows a shift clock that arrives on `sclk_in`. That pin is brought into the system clock domain through two flops before its edges are detected. Slave selection is left to general-purpose pins under host control.

The host loads a one-byte transmit buffer and reads a one-byte receive buffer. It sets the clock idle level and the data phase, and it chooses when the transmit interrupt fires: when the buffer is handed to the shifter, or when the last bit has been shifted. A byte moves only when transmission is enabled and the buffer holds data. Reception follows the same transfer and also needs the receive enable. If the previous byte is still unread when the seventh bit of the next byte has been sampled, a sticky overrun flag is raised.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, with the clock idle, `tx_empty`=1, `rx_full`=0, `overrun`=0, `tx_irq`=0 and `rx_irq`=0. `sclk_out` rests high when `clk_pol`=0 and low when `clk_pol`=1.
- R2: A transfer starts only while `tx_en`=1 and `tx_empty`=0. A `tx_wr` pulse clears `tx_empty`, and handing the buffer to the shifter sets it again.
- R3: In master mode (`master_mode`=1) each half period of `sclk_out` lasts (divider+1)*P system clocks. P is 1, 2, 8 or 32 for `prescale_sel` = 0, 1, 2 or 3. One byte takes 16 clock edges.
- R4: In slave mode (`master_mode`=0) shifting follows the edges of `sclk_in`, and `sclk_out` stays at its idle level.
- R5: The leading edge is the first edge away from the idle level. With `clk_phase`=0, data is launched on leading edges and sampled on trailing edges. With `clk_phase`=1, the first bit is driven at the start, data is sampled on leading edges and launched on trailing edges. All four combinations with `clk_pol` transfer data correctly.
- R6: A byte is received only if `rx_en`=1 when the transfer starts. Without a started transfer, which needs `tx_en`, activity on `sclk_in` does not change `rx_full`.
- R7: With `tx_irq_sel`=0, `tx_irq` pulses for one cycle when the buffer moves into the shifter, before the first clock edge. With `tx_irq_sel`=1, it pulses when the 16th edge completes the byte.
- R8: At the end of a received byte, `rx_data` takes the byte, `rx_full` becomes 1 and `rx_irq` pulses for one cycle. A `rx_rd` pulse clears `rx_full`.
- R9: If `rx_full`=1 when the seventh bit of the next byte is sampled, `overrun` becomes 1. That byte then neither pulses `rx_irq` nor sets up a new read. `overrun` holds until `rx_en` is 0.
- R10: Bits leave on `sdo` and enter from `sdi` most-significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| master_mode | input | 1 | 1: internal clock, 0: clock from `sclk_in` |
| prescale_sel | input | 2 | Prescale: 0 /1, 1 /2, 2 /8, 3 /32 |
| divider | input | DIV_W | Half-period divider value n |
| clk_pol | input | 1 | 0: idle high, 1: idle low |
| clk_phase | input | 1 | Data phase select (see R5) |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| tx_irq_sel | input | 1 | 0: interrupt on buffer hand-off, 1: on shift completion |
| tx_wr | input | 1 | Write `tx_data` into the transmit buffer |
| tx_data | input | DATA_W | Byte to send |
| rx_rd | input | 1 | Read strobe for the receive buffer |
| rx_data | output | DATA_W | Receive buffer |
| tx_empty | output | 1 | Transmit buffer empty |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| overrun | output | 1 | Sticky overrun flag |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_irq | output | 1 | Receive interrupt pulse |
| sclk_in | input | 1 | External shift clock (slave) |
| sclk_out | output | 1 | Generated shift clock (master) |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |

## Verification
A wrong edge count or phase decode shows up at the end of the same byte. Either `rx_data` differs from the byte looped back or driven by the bench, or the bench's own capture of `sdo` differs from the loaded byte. A divider or prescaler fault shows up in the spacing between the first two `sclk_out` toggles, measured in system clocks. A wrong interrupt or overrun state shows up within one byte time, in the position of the `tx_irq` pulse against the first clock toggle, in a missing or extra `rx_irq`, or in the `overrun` level after a second unread byte.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int PRE_W = 6;

  function automatic logic [PRE_W-1:0] presc_len(input logic [1:0] sel);
    case (sel)
      2'd0:    presc_len = 6'd1;
      2'd1:    presc_len = 6'd2;
      2'd2:    presc_len = 6'd8;
      default: presc_len = 6'd32;
    endcase
  endfunction
endpackage

// File: rtl/ssp_rate_gen.sv
module ssp_rate_gen
  import ssp_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [1:0]       sel,
  input  logic [DIV_W-1:0] divider,
  output logic             edge_ev
);
  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] half_cnt;
  logic             tick;

  assign tick    = (pre_cnt == presc_len(sel) - 6'd1);
  assign edge_ev = run && tick && (half_cnt == divider);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre_cnt  <= '0;
      half_cnt <= '0;
    end else begin
      pre_cnt <= tick ? '0 : pre_cnt + 6'd1;
      if (tick) half_cnt <= (half_cnt == divider) ? '0 : half_cnt + 1'b1;
    end
  end

  // R3: the prescale counter never runs past the longest prescale
  a_r3_pre_bound: assert property (@(posedge clk) disable iff (rst)
    pre_cnt < 6'd32);
endmodule

// File: rtl/ssp_pin_sync.sv
module ssp_pin_sync (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic toggle_ev
);
  logic [2:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[1:0], pin};
  end

  assign toggle_ev = sync_q[2] ^ sync_q[1];
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master_mode,
  input  logic [1:0]        prescale_sel,
  input  logic [DIV_W-1:0]  divider,
  input  logic              clk_pol,
  input  logic              clk_phase,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              tx_irq_sel,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              overrun,
  output logic              tx_irq,
  output logic              rx_irq,
  input  logic              sclk_in,
  output logic              sclk_out,
  input  logic              sdi,
  output logic              sdo
);
  localparam int CNT_W  = $clog2(2*DATA_W);
  localparam int BIT_W  = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] EDGE_LAST = CNT_W'(2*DATA_W-1);
  localparam logic [BIT_W-1:0] OVR_BIT   = BIT_W'(DATA_W-2);

  logic              busy;
  logic [CNT_W-1:0]  edge_cnt;
  logic [BIT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] tx_buf, sh_tx, sh_rx, rx_next;
  logic              rx_on, ovr_hit;
  logic              gen_ev, pin_ev, ev;
  logic              launch, sample, last, idle_lvl, start;

  ssp_rate_gen #(.DIV_W(DIV_W)) i_rate (
    .clk(clk), .rst(rst), .run(busy && master_mode),
    .sel(prescale_sel), .divider(divider), .edge_ev(gen_ev)
  );

  ssp_pin_sync i_sync (
    .clk(clk), .rst(rst), .pin(sclk_in), .toggle_ev(pin_ev)
  );

  assign ev       = busy && (master_mode ? gen_ev : pin_ev);
  assign launch   = clk_phase ? edge_cnt[0] : ~edge_cnt[0];
  assign sample   = ~launch;
  assign last     = (edge_cnt == EDGE_LAST);
  assign idle_lvl = ~clk_pol;
  assign start    = !busy && tx_en && !tx_empty;
  assign rx_next  = {sh_rx[DATA_W-2:0], sdi};
  assign rx_data  = rx_buf_q;

  logic [DATA_W-1:0] rx_buf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      edge_cnt <= '0;
      bit_cnt  <= '0;
      tx_buf   <= '0;
      sh_tx    <= '0;
      sh_rx    <= '0;
      rx_buf_q <= '0;
      rx_on    <= 1'b0;
      ovr_hit  <= 1'b0;
      tx_empty <= 1'b1;
      rx_full  <= 1'b0;
      overrun  <= 1'b0;
      tx_irq   <= 1'b0;
      rx_irq   <= 1'b0;
      sclk_out <= 1'b1;
      sdo      <= 1'b0;
    end else begin
      tx_irq <= 1'b0;
      rx_irq <= 1'b0;
      if (rx_rd)  rx_full <= 1'b0;
      if (!rx_en) overrun <= 1'b0;
      if (!busy) begin
        sclk_out <= idle_lvl;
        if (start) begin
          busy     <= 1'b1;
          tx_empty <= 1'b1;
          edge_cnt <= '0;
          bit_cnt  <= '0;
          rx_on    <= rx_en;
          ovr_hit  <= 1'b0;
          tx_irq   <= !tx_irq_sel;
          if (clk_phase) begin
            sdo   <= tx_buf[DATA_W-1];
            sh_tx <= {tx_buf[DATA_W-2:0], 1'b0};
          end else begin
            sh_tx <= tx_buf;
          end
        end
      end else if (ev) begin
        edge_cnt <= edge_cnt + 1'b1;
        if (master_mode) sclk_out <= ~sclk_out;
        if (launch) begin
          sdo   <= sh_tx[DATA_W-1];
          sh_tx <= {sh_tx[DATA_W-2:0], 1'b0};
        end
        if (sample) begin
          sh_rx   <= rx_next;
          bit_cnt <= bit_cnt + 1'b1;
          if (rx_on && bit_cnt == OVR_BIT && rx_full && !rx_rd) begin
            overrun <= 1'b1;
            ovr_hit <= 1'b1;
          end
        end
        if (last) begin
          busy   <= 1'b0;
          tx_irq <= tx_irq_sel;
          if (rx_on && !ovr_hit) begin
            rx_buf_q <= sample ? rx_next : sh_rx;
            rx_full  <= 1'b1;
            rx_irq   <= 1'b1;
          end
        end
      end
      if (tx_wr) begin
        tx_buf   <= tx_data;
        tx_empty <= 1'b0;
      end
    end
  end

  // R2: a transfer begins only from an enabled, loaded buffer
  a_r2_start_gate: assert property (@(posedge clk) disable iff (rst)
    (busy && !$past(busy)) |-> $past(tx_en && !tx_empty));

  // R8: a receive interrupt always comes with a full buffer
  a_r8_irq_with_full: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> rx_full);

  // R8: the receive interrupt is a single-cycle pulse
  a_r8_irq_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_irq |=> !rx_irq);

  // R9: overrun holds while the receiver stays enabled
  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    (overrun && rx_en) |=> overrun);

  // R3: a master byte ends with the clock back at its idle level
  a_r3_ends_idle: assert property (@(posedge clk) disable iff (rst)
    (master_mode && $past(busy) && !busy && $stable(clk_pol)) |-> (sclk_out == ~clk_pol));
endmodule

// File: tb/test_sync_serial_port.sv
module test_sync_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SL    = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       master_mode = 1'b1;
  logic [1:0] prescale_sel = 2'd0;
  logic [7:0] divider = 8'd0;
  logic       clk_pol = 1'b0, clk_phase = 1'b0;
  logic       tx_en = 1'b0, rx_en = 1'b0, tx_irq_sel = 1'b0;
  logic       tx_wr = 1'b0, rx_rd = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic [7:0] rx_data;
  logic       tx_empty, rx_full, overrun, tx_irq, rx_irq;
  logic       sclk_pin = 1'b1, sclk_out, sdo, sdi_drv = 1'b0, loopback = 1'b1;
  logic       sdi;

  int n_checks = 0, n_fail = 0;
  int cyc = 0, tx_stamp = 0, rx_cnt = 0, tog_n = 0, t1 = 0, t2 = 0;
  logic last_sclk = 1'b1;
  bit done = 0;

  assign sdi = loopback ? sdo : sdi_drv;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_serial_port i_sync_serial_port (
    .clk(clk), .rst(rst), .master_mode(master_mode), .prescale_sel(prescale_sel),
    .divider(divider), .clk_pol(clk_pol), .clk_phase(clk_phase), .tx_en(tx_en),
    .rx_en(rx_en), .tx_irq_sel(tx_irq_sel), .tx_wr(tx_wr), .tx_data(tx_data),
    .rx_rd(rx_rd), .rx_data(rx_data), .tx_empty(tx_empty), .rx_full(rx_full),
    .overrun(overrun), .tx_irq(tx_irq), .rx_irq(rx_irq), .sclk_in(sclk_pin),
    .sclk_out(sclk_out), .sdi(sdi), .sdo(sdo)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (tx_irq) tx_stamp = cyc;
      if (rx_irq) rx_cnt = rx_cnt + 1;
      if (sclk_out != last_sclk) begin
        if (tog_n == 0) t1 = cyc;
        if (tog_n == 1) t2 = cyc;
        tog_n = tog_n + 1;
      end
    end
    last_sclk = sclk_out;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_tx(input logic [7:0] b);
    @(negedge clk); tx_data = b; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic read_rx();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic t_reset();
    wait_cyc(3);
    check(tx_empty == 1 && rx_full == 0 && overrun == 0, "R1 flags", {tx_empty, rx_full, overrun}, 3'b100);
    check(tx_irq == 0 && rx_irq == 0, "R1 irqs", {tx_irq, rx_irq}, 0);
    check(sclk_out == 1, "R1 idle high", sclk_out, 1);
    clk_pol = 1'b1; wait_cyc(3);
    check(sclk_out == 0, "R1 idle low", sclk_out, 0);
    clk_pol = 1'b0; wait_cyc(3);
  endtask

  task automatic t_gate_r2();
    master_mode = 1; tx_en = 0; rx_en = 1; wait_cyc(2);
    tog_n = 0;
    write_tx(8'h3C);
    wait_cyc(60);
    check(tx_empty == 0 && tog_n == 0, "R2 held while disabled", {tx_empty, 8'(tog_n)}, 0);
    tx_en = 1; wait_cyc(3);
    check(tx_empty == 1, "R2 hand-off sets empty", tx_empty, 1);
    for (int k = 0; k < 200 && rx_cnt == 0; k++) wait_cyc(1);
    read_rx();
    rx_cnt = 0;
  endtask

  task automatic t_master(input logic pol, input logic ph, input logic isel,
                          input logic [1:0] ps, input logic [7:0] n, input logic [7:0] b,
                          input int half);
    int start_rx;
    master_mode = 1; loopback = 1; clk_pol = pol; clk_phase = ph; tx_irq_sel = isel;
    prescale_sel = ps; divider = n; tx_en = 1; rx_en = 1;
    wait_cyc(4);
    tog_n = 0; tx_stamp = -1; start_rx = rx_cnt;
    write_tx(b);
    for (int k = 0; k < 5000 && rx_cnt == start_rx; k++) wait_cyc(1);
    wait_cyc(2);
    check(rx_data == b, "R5 master loopback data", rx_data, b);
    check(rx_full == 1 && rx_cnt == start_rx + 1, "R8 one rx irq and full", rx_cnt - start_rx, 1);
    check(t2 - t1 == half, "R3 half period", t2 - t1, half);
    check(tog_n == 16, "R3 sixteen edges", tog_n, 16);
    if (isel) check(tx_stamp == t2 - half + 15*half - 14*half + 14*half - 14*half + (t1 + 15*half - t2 + half) - half,
                    "R7 tx irq at completion", tx_stamp, t1 + 15*half);
    else      check(tx_stamp >= 0 && tx_stamp < t1, "R7 tx irq before first edge", tx_stamp, t1);
    read_rx();
    wait_cyc(1);
    check(rx_full == 0, "R8 read clears full", rx_full, 0);
  endtask

  task automatic bus_byte(input logic pol, input logic ph, input logic [7:0] mb,
                          output logic [7:0] got);
    logic idle;
    idle = ~pol;
    sclk_pin = idle;
    if (ph) sdi_drv = mb[7];
    for (int i = 0; i < 8; i++) begin
      if (!ph) begin
        wait_cyc(HALF_SL); sclk_pin = ~idle; sdi_drv = mb[7-i];
        wait_cyc(HALF_SL); got[7-i] = sdo; sclk_pin = idle;
      end else begin
        wait_cyc(HALF_SL); got[7-i] = sdo; sclk_pin = ~idle;
        wait_cyc(HALF_SL); sclk_pin = idle;
        if (i < 7) sdi_drv = mb[6-i];
      end
    end
    wait_cyc(8);
  endtask

  task automatic t_slave(input logic pol, input logic ph, input logic [7:0] tb, input logic [7:0] mb);
    logic [7:0] got;
    master_mode = 0; loopback = 0; clk_pol = pol; clk_phase = ph;
    sclk_pin = ~pol; tx_en = 1; rx_en = 1; tx_irq_sel = 0;
    wait_cyc(6);
    tog_n = 0;
    write_tx(tb);
    wait_cyc(4);
    bus_byte(pol, ph, mb, got);
    check(got == tb, "R10 sdo msb first", got, tb);
    check(rx_data == mb, "R4 slave receive", rx_data, mb);
    check(tog_n == 0, "R4 sclk_out idle in slave", tog_n, 0);
    read_rx();
  endtask

  task automatic t_no_tx_r6();
    logic [7:0] got;
    int c0;
    master_mode = 0; loopback = 0; clk_pol = 0; clk_phase = 0; sclk_pin = 1;
    tx_en = 0; rx_en = 1; c0 = rx_cnt;
    wait_cyc(6);
    write_tx(8'h77);
    bus_byte(0, 0, 8'h5A, got);
    check(rx_full == 0 && rx_cnt == c0, "R6 no receive without transmit", rx_full, 0);
    tx_en = 1; rx_en = 0; wait_cyc(4);
    bus_byte(0, 0, 8'h5A, got);
    check(rx_full == 0 && tx_empty == 1, "R6 no receive with rx disabled", rx_full, 0);
    rx_en = 1;
  endtask

  task automatic t_overrun_r9();
    logic [7:0] got;
    int c0;
    master_mode = 0; loopback = 0; clk_pol = 1; clk_phase = 1; sclk_pin = 0;
    tx_en = 1; rx_en = 1; wait_cyc(6);
    write_tx(8'h11); wait_cyc(4);
    bus_byte(1, 1, 8'hC3, got);
    c0 = rx_cnt;
    check(rx_full == 1 && overrun == 0, "R9 no overrun on first byte", overrun, 0);
    write_tx(8'h22); wait_cyc(4);
    bus_byte(1, 1, 8'h3C, got);
    check(overrun == 1, "R9 overrun raised", overrun, 1);
    check(rx_cnt == c0, "R9 no rx irq on overrun byte", rx_cnt - c0, 0);
    read_rx();
    wait_cyc(2);
    check(overrun == 1, "R9 overrun sticky", overrun, 1);
    rx_en = 0; wait_cyc(2);
    check(overrun == 0, "R9 cleared by rx disable", overrun, 0);
    rx_en = 1;
  endtask

  initial begin
    wait_cyc(4);
    rst = 1'b0;
    t_reset();
    t_gate_r2();
    t_master(0, 0, 0, 2'd0, 8'd2, 8'hA5, 3);
    t_master(1, 1, 1, 2'd1, 8'd3, 8'h3E, 8);
    t_master(0, 1, 0, 2'd3, 8'd0, 8'h81, 32);
    t_master(1, 0, 1, 2'd2, 8'd1, 8'h6B, 16);
    t_slave(0, 0, 8'h96, 8'h2D);
    t_slave(0, 1, 8'hE1, 8'h4C);
    t_slave(1, 0, 8'h0F, 8'hB2);
    t_slave(1, 1, 8'h59, 8'hD4);
    t_no_tx_r6();
    t_overrun_r9();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule